// File: doc/BRIEF.md
# Synchronous Burst Static Memory Core

This block is a single-ported synchronous memory of 36-bit words, organised as four 9-bit byte lanes. In each lane the top bit is the parity bit. Every control and data input is taken on the rising clock edge. The registered address feeds an internal 2-bit burst counter, so a master hands over one address and then steps through the rest of a four-word group with a single advance strobe.

A cycle can be opened by either of two active-low start strobes. The processor start strobe only counts while the primary select is low, always opens a read, and wins when both strobes are low. The controller start strobe opens a read or a write, depending on the write controls. A write lands one edge after its address is registered. The write lanes come from the per-lane enables, or from the global write, which forces every lane. The burst order is linear or interleaved, as chosen by the mode input at the start of the burst. Read data comes out as a data word plus a drive-enable for the pad ring. The drive-enable is gated without a clock by the active-low output enable.

The controller is a three-state machine with the states IDLE, READ and WRITE. Transitions:
- **Deselect:** any start while not selected goes to IDLE.
- **Open read:** a processor start, or a controller start with no write control asserted, goes to READ.
- **Open write:** a controller start with a write control asserted goes to WRITE.
- **Continue:** READ or WRITE with no start goes to WRITE if a write control is asserted, and to READ otherwise. The address steps if the advance strobe is low.
- **Stay idle:** IDLE with no start stays in IDLE.

Top module: `sbram_core`

## Requirements
- R1: A start registers the full address on the rising edge. In READ, the word at the registered address is on `rdata` in the cycle after that edge.
- R2: The device is selected only when `sel_n`=0, `sel2_n`=0 and `sel2`=1 all hold at the start edge. A start while not selected enters IDLE. In IDLE, `rdata_oe` stays 0 and the advance strobe has no effect.
- R3: `start_p_n` is ignored while `sel_n` is 1. It neither opens nor ends a cycle, and an open burst continues.
- R4: When both start strobes are low and `sel_n` is 0, the processor strobe wins. The cycle is a read, and `wr_all_n` and `lane_wr_n` are ignored.
- R5: With `ilv_mode`=0 (linear), each advance adds 1 modulo 4 to the low two address bits.
- R6: With `ilv_mode`=1 (interleaved), the low two address bits are the loaded low bits XOR the counter value 0, 1, 2, 3.
- R7: With `step_n`=1 and no start, the address holds.
- R8: The counter is 2 bits wide. The fourth advance returns to the loaded address, and the bits above the low two never change within a burst.
- R9: `lane_wr_n[i]`=0 writes bits [9i+8:9i] of `wdata`, parity bit 9i+8 included. The other lanes keep their contents.
- R10: `wr_all_n`=0 writes all four lanes whatever `lane_wr_n` holds.
- R11: A write uses the `wdata` present at the edge after the edge that registered or advanced its address.
- R12: `rdata_oe` is 1 only while `out_en_n`=0 and the state is READ. At all other times `rdata` is 0.
- R13: After reset the state is IDLE and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the controller |
| addr | input | ADDR_W | Word address, taken on a start |
| start_p_n | input | 1 | Processor start strobe, active low |
| start_c_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance strobe, active low |
| sel_n | input | 1 | Primary select, active low |
| sel2_n | input | 1 | Secondary select, active low |
| sel2 | input | 1 | Secondary select, active high |
| wr_all_n | input | 1 | Global write, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| ilv_mode | input | 1 | 1 selects interleaved order, 0 selects linear |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdata_oe | output | 1 | Drive-enable for the data pads |

## Verification
The memory array write of the previous address and the address step or new load both happen on the same edge. A write burst that advances on every cycle, and then holds in READ on its last address, puts the closing write and the read of that same word into one cycle. The bench judges this by expecting the freshly written word on `rdata` in that cycle. A start with both strobes low and write controls asserted puts a possible write and the priority decision on one edge. This case is judged by reading the word back unchanged over two cycles.

// File: rtl/sbram_pkg.sv
package sbram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } bst_e;

    // Low two address bits for a burst position.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/sbram_ctl.sv
module sbram_ctl
    import sbram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              start_p_n,
    input  logic              start_c_n,
    input  logic              step_n,
    input  logic              sel_n,
    input  logic              sel2_n,
    input  logic              sel2,
    input  logic              wr_all_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              ilv_mode,
    output bst_e              st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  wr_mask
);

    localparam int HI_W = ADDR_W - 2;

    bst_e             st_q, st_d;
    logic [HI_W-1:0]  hi_q, hi_d;
    logic [1:0]       base_q, base_d;
    logic [1:0]       cnt_q, cnt_d;
    logic             ilv_q, ilv_d;
    logic [LANES-1:0] mask_q, mask_d;

    logic             selected;
    logic             go_p;
    logic             go_c;
    logic             wr_req;
    logic [LANES-1:0] req_mask;

    always_comb begin
        selected = !sel_n && !sel2_n && sel2;
        go_p     = !start_p_n && !sel_n;
        go_c     = !start_c_n && !go_p;
        wr_req   = !wr_all_n || (|(~lane_wr_n));
        req_mask = wr_all_n ? ~lane_wr_n : {LANES{1'b1}};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            st_q   <= st_d;
            hi_q   <= hi_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            ilv_q  <= ilv_d;
            mask_q <= mask_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        hi_d   = hi_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        ilv_d  = ilv_q;
        mask_d = '0;
        if (go_p || go_c) begin
            if (!selected) begin
                st_d = ST_IDLE;
            end else begin
                hi_d   = addr[ADDR_W-1:2];
                base_d = addr[1:0];
                cnt_d  = 2'd0;
                ilv_d  = ilv_mode;
                if (go_c && wr_req) begin
                    st_d   = ST_WR;
                    mask_d = req_mask;
                end else begin
                    st_d = ST_RD;
                end
            end
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_RD, ST_WR: begin
                    if (!step_n) cnt_d = cnt_q + 2'd1;
                    if (wr_req) begin
                        st_d   = ST_WR;
                        mask_d = req_mask;
                    end else begin
                        st_d = ST_RD;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        st       = st_q;
        cur_addr = {hi_q, burst_low(base_q, cnt_q, ilv_q)};
        wr_mask  = (st_q == ST_WR) ? mask_q : '0;
    end

endmodule

// File: rtl/sbram_lane.sv
module sbram_lane #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sbram_core.sv
module sbram_core
    import sbram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    start_p_n,
    input  logic                    start_c_n,
    input  logic                    step_n,
    input  logic                    sel_n,
    input  logic                    sel2_n,
    input  logic                    sel2,
    input  logic                    wr_all_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    ilv_mode,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);

    localparam int DATA_W = LANES * LANE_W;

    bst_e              st;
    logic [ADDR_W-1:0] cur_addr;
    logic [LANES-1:0]  wr_mask;
    logic [DATA_W-1:0] word;

    sbram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .start_p_n (start_p_n),
        .start_c_n (start_c_n),
        .step_n    (step_n),
        .sel_n     (sel_n),
        .sel2_n    (sel2_n),
        .sel2      (sel2),
        .wr_all_n  (wr_all_n),
        .lane_wr_n (lane_wr_n),
        .ilv_mode  (ilv_mode),
        .st        (st),
        .cur_addr  (cur_addr),
        .wr_mask   (wr_mask)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sbram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    (wr_mask[i]),
            .addr  (cur_addr),
            .wdata (wdata[i*LANE_W +: LANE_W]),
            .rdata (word[i*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        rdata_oe = !out_en_n && (st == ST_RD);
        rdata    = rdata_oe ? word : '0;
    end

endmodule

// File: rtl/sbram_core_chk.sv
module sbram_core_chk
    import sbram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              start_p_n,
    input logic              start_c_n,
    input logic              step_n,
    input logic              sel_n,
    input logic              sel2_n,
    input logic              sel2,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input bst_e              st,
    input logic [ADDR_W-1:0] cur_addr
);

    logic sel_ok, any_go, go_p;
    assign sel_ok = !sel_n && !sel2_n && sel2;
    assign go_p   = !start_p_n && !sel_n;
    assign any_go = go_p || !start_c_n;

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (any_go && sel_ok) |=> (cur_addr == $past(addr)));

    p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_go && !sel_ok) |=> (st == ST_IDLE && !rdata_oe));

    p_proc_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_p && sel_ok) |=> (st == ST_RD));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !any_go && step_n) |=> $stable(cur_addr));

    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !any_go && !step_n) |=>
        (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]) &&
         cur_addr[1:0] != $past(cur_addr[1:0])));

    p_oe_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!rdata_oe && rdata == '0));

endmodule

bind sbram_core sbram_core_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (.*);

// File: tb/sbram_core_test.sv
`timescale 1ns/1ps
module sbram_core_test;

    localparam int ADDR_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;

    localparam logic [DW-1:0] A0 = 36'h123456789;
    localparam logic [DW-1:0] A1 = 36'h9ABCDEF01;
    localparam logic [DW-1:0] A2 = 36'h13579BDF2;
    localparam logic [DW-1:0] A3 = 36'h2468ACE03;
    localparam logic [DW-1:0] WX = 36'hC0FFEE555;
    localparam logic [DW-1:0] FF = 36'hFFFFFFFFF;

    typedef struct packed {
        logic              p_n, c_n, stp_n, s_n, s2_n, s2, gw_n;
        logic [LANES-1:0]  bw_n;
        logic              ilv, oe_n;
        logic [ADDR_W-1:0] a;
        logic [DW-1:0]     wd;
        logic              e_oe;
        logic [DW-1:0]     e_q;
        logic [3:0]        req;
    } vec_t;

    function automatic vec_t mk(input logic p_n, c_n, stp_n, s_n, s2_n, s2, gw_n,
                                input logic [LANES-1:0] bw_n, input logic ilv, oe_n,
                                input logic [ADDR_W-1:0] a, input logic [DW-1:0] wd,
                                input logic e_oe, input logic [DW-1:0] e_q,
                                input logic [3:0] req);
        vec_t v;
        v.p_n = p_n; v.c_n = c_n; v.stp_n = stp_n; v.s_n = s_n; v.s2_n = s2_n;
        v.s2 = s2; v.gw_n = gw_n; v.bw_n = bw_n; v.ilv = ilv; v.oe_n = oe_n;
        v.a = a; v.wd = wd; v.e_oe = e_oe; v.e_q = e_q; v.req = req;
        return v;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, new_w,
                                            input logic [LANES-1:0] en);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < LANES; i++)
            if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        return r;
    endfunction

    localparam int NV = 30;
    // fields: p_n c_n stp_n s_n s2_n s2 gw_n bw_n ilv oe_n addr wdata | exp_oe exp_q req
    localparam vec_t VEC [NV] = '{
        mk(1,0,1,0,0,1,0,4'hF,0,0,8'h10,'0, 0,'0, 4'd11), // R11 open write burst
        mk(1,1,0,0,0,1,0,4'hF,0,0,8'h00,A0, 0,'0, 4'd11),
        mk(1,1,0,0,0,1,0,4'hF,0,0,8'h00,A1, 0,'0, 4'd11),
        mk(1,1,0,0,0,1,0,4'hF,0,0,8'h00,A2, 0,'0, 4'd11),
        mk(1,1,1,0,0,1,1,4'hF,0,0,8'h00,A3, 1,A3, 4'd11), // R11 last write then read same word
        mk(0,1,1,0,0,1,1,4'hF,0,0,8'h11,'0, 1,A1, 4'd1),  // R1
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A2, 4'd5),  // R5
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A3, 4'd5),
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A0, 4'd5),
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A1, 4'd8),  // R8 wrap
        mk(1,1,1,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A1, 4'd7),  // R7 hold
        mk(0,1,1,0,0,1,1,4'hF,1,0,8'h11,'0, 1,A1, 4'd6),  // R6 interleaved
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A0, 4'd6),
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A3, 4'd6),
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A2, 4'd6),
        mk(1,1,1,0,0,1,1,4'hF,0,1,8'h00,'0, 0,'0, 4'd12), // R12 output disabled
        mk(0,1,1,1,0,1,1,4'hF,0,0,8'h10,'0, 1,A2, 4'd3),  // R3 ignored, burst holds
        mk(1,0,1,0,0,1,1,4'hA,0,0,8'h11,'0, 0,'0, 4'd9),  // R9 lanes 0,2
        mk(1,1,1,0,0,1,1,4'hF,0,0,8'h00,FF, 1,merge(A1,FF,4'h5), 4'd9),
        mk(1,0,1,0,0,1,0,4'hF,0,0,8'h12,'0, 0,'0, 4'd10), // R10 global write
        mk(1,1,1,0,0,1,1,4'hF,0,0,8'h00,WX, 1,WX, 4'd10),
        mk(0,0,1,0,0,1,0,4'h0,0,0,8'h13,'0, 1,A3, 4'd4),  // R4 priority read
        mk(1,1,1,0,0,1,1,4'hF,0,0,8'h00,'0, 1,A3, 4'd4),
        mk(1,0,1,0,0,0,1,4'hF,0,0,8'h10,'0, 0,'0, 4'd2),  // R2 sel2 low
        mk(1,1,0,0,0,1,1,4'hF,0,0,8'h00,'0, 0,'0, 4'd2),
        mk(1,0,1,0,1,1,1,4'hF,0,0,8'h10,'0, 0,'0, 4'd2),  // R2 sel2_n high
        mk(0,1,1,0,0,1,1,4'hF,0,0,8'h10,'0, 1,A0, 4'd2),
        mk(1,0,1,1,0,1,1,4'hF,0,0,8'h10,'0, 0,'0, 4'd2),  // R2 sel_n high
        mk(0,1,1,0,0,0,1,4'hF,0,0,8'h10,'0, 0,'0, 4'd2),
        mk(0,1,1,1,0,1,1,4'hF,0,0,8'h10,'0, 0,'0, 4'd3)   // R3 from idle
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              start_p_n = 1'b1, start_c_n = 1'b1, step_n = 1'b1;
    logic              sel_n = 1'b0, sel2_n = 1'b0, sel2 = 1'b1;
    logic              wr_all_n = 1'b1, ilv_mode = 1'b0, out_en_n = 1'b0;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              rdata_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sbram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .start_p_n(start_p_n),
        .start_c_n(start_c_n), .step_n(step_n), .sel_n(sel_n), .sel2_n(sel2_n),
        .sel2(sel2), .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n),
        .ilv_mode(ilv_mode), .out_en_n(out_en_n), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input int req, input int step, input logic [DW:0] act,
                         input logic [DW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d step %0d: actual oe/q=%h expected %h", req, step, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        start_p_n = v.p_n; start_c_n = v.c_n; step_n = v.stp_n; sel_n = v.s_n;
        sel2_n = v.s2_n; sel2 = v.s2; wr_all_n = v.gw_n; lane_wr_n = v.bw_n;
        ilv_mode = v.ilv; out_en_n = v.oe_n; addr = v.a; wdata = v.wd;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(13, -1, {rdata_oe, rdata}, '0); // R13 reset state, bus not driven
        rst_n = 1'b1;
        @(negedge clk);
        check(13, -2, {rdata_oe, rdata}, '0); // R13 idle after release
        for (int k = 0; k < NV; k++) begin
            apply(VEC[k]);
            @(posedge clk);
            @(negedge clk);
            check(int'(VEC[k].req), k, {rdata_oe, rdata}, {VEC[k].e_oe, VEC[k].e_q});
        end
        // R12: output enable acts without a clock edge
        apply(mk(0,1,1,0,0,1,1,4'hF,0,0,8'h12,'0, 1,WX, 4'd12));
        @(posedge clk);
        @(negedge clk);
        check(12, 100, {rdata_oe, rdata}, {1'b1, WX});
        out_en_n = 1'b1;
        #2;
        check(12, 101, {rdata_oe, rdata}, '0);
        out_en_n = 1'b0;
        #2;
        check(12, 102, {rdata_oe, rdata}, {1'b1, WX});
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule